// File: doc/BRIEF.md
# General-Purpose I/O Bank with Event Detection

This block is a 32-pin general-purpose I/O bank that a processor controls through a small word-addressed register bus. Each pin carries a 3-bit function code. The code decides whether the pin is an input or a driven output, or whether it is handed to one of six alternate peripherals. The bank only stores and exports these codes. Output levels change through two write-only masks, one that sets pins and one that clears them, so software never has to read, modify and write the output state.

Pin inputs pass through a synchroniser before anything else uses them. The synchronised value is readable as a level word. It also feeds four independent detectors, which look for rising edges, falling edges, a high level and a low level, each gated by its own per-pin enable mask. Detected events collect in a sticky status word. Software clears a status bit by writing a 1 to it. One interrupt line is raised while any status bit is set.

Top module: `gpio_evt_bank`

## Requirements
- R1: Pin p's function code occupies bits (p mod 10)*3 .. (p mod 10)*3+2 of select word p/10, which sits at word addresses 0 to 3. A read returns the stored codes, and bits not covered by a pin read as 0.
- R2: Code 3'b001 raises the pin's output enable. Code 3'b000 and the alternate codes 3'b010 to 3'b111 leave it low. Every pin's code is exported on pin_func bits [3p+2:3p].
- R3: A write to word 4 sets the output latch of every pin whose data bit is 1 and leaves the other pins unchanged, visible on pin_dout one cycle after the write.
- R4: A write to word 5 clears the output latch of every pin whose data bit is 1 and leaves the other pins unchanged.
- R5: Word 6 reads the pin inputs after a two-stage synchroniser.
- R6: Words 7 and 8 enable rising-edge and falling-edge detection per pin. With both enabled, either edge on that pin is detected.
- R7: Words 9 and 10 enable high-level and low-level detection per pin. A level event keeps setting its status bit for as long as the pin stays at the enabled level, even right after a clear.
- R8: The status word (word 11) is sticky. Writing 1 clears a bit and writing 0 leaves it alone. An event that arrives in the same cycle as its clear leaves the bit set.
- R9: irq is high exactly when at least one status bit is set.
- R10: After reset, all codes are input, all enables and status bits are 0, and the output latches are 0.
- R11: Read data appears on bus_rdata in the cycle after bus_rd. Unmapped words and the set and clear words read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 4 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pin_in | input | 32 | Asynchronous pin inputs |
| pin_dout | output | 32 | Output latch values |
| pin_oe | output | 32 | Output enable per pin (code 3'b001) |
| pin_func | output | 96 | Per-pin 3-bit function codes |
| irq | output | 1 | OR of all status bits |

## Verification
The assertions assume that bus_wr and bus_rd are never high together and that pin_in changes at most once per clock. Under these assumptions a change on a pin is seen by the detectors two cycles later. The stimulus issues one bus operation per transfer and changes pin_in only on the falling clock edge. After each pin change it waits at least four cycles before reading the level or status, so every expected value is settled and no metastable sample is modelled.

// File: rtl/gpio_evt_pkg.sv
package gpio_evt_pkg;
    localparam int NPIN         = 32;
    localparam int DATA_W       = 32;
    localparam int ADDR_W       = 4;
    localparam int FSEL_W       = 3;
    localparam int PINS_PER_SEL = 10;
    localparam int NSEL         = (NPIN + PINS_PER_SEL - 1) / PINS_PER_SEL;
    localparam int SYNC_DEPTH   = 2;

    typedef enum logic [ADDR_W-1:0] {
        RI_SEL0 = 4'd0,
        RI_SEL1 = 4'd1,
        RI_SEL2 = 4'd2,
        RI_SEL3 = 4'd3,
        RI_SET  = 4'd4,
        RI_CLR  = 4'd5,
        RI_LVL  = 4'd6,
        RI_RISE = 4'd7,
        RI_FALL = 4'd8,
        RI_HIGH = 4'd9,
        RI_LOW  = 4'd10,
        RI_STS  = 4'd11
    } reg_idx_e;

    typedef enum logic [FSEL_W-1:0] {
        FN_IN     = 3'd0,
        FN_OUT    = 3'd1,
        FN_PERIPH0 = 3'd2,
        FN_PERIPH1 = 3'd3,
        FN_PERIPH2 = 3'd4,
        FN_PERIPH3 = 3'd5,
        FN_PERIPH4 = 3'd6,
        FN_PERIPH5 = 3'd7
    } fn_code_e;

    typedef struct packed {
        logic [NPIN-1:0] rise;
        logic [NPIN-1:0] fall;
        logic [NPIN-1:0] high;
        logic [NPIN-1:0] low;
    } det_en_t;

    function automatic int sel_idx(input int p);
        return p / PINS_PER_SEL;
    endfunction

    function automatic int sel_off(input int p);
        return (p % PINS_PER_SEL) * FSEL_W;
    endfunction
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W      = 32,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stg_q [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
        end else begin
            stg_q[0] <= d_i;
            for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
        end
    end

    assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/gpio_event.sv
module gpio_event
    import gpio_evt_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [NPIN-1:0] lvl_i,
    input  det_en_t         en_i,
    input  logic [NPIN-1:0] clr_i,
    output logic [NPIN-1:0] sts_o
);
    logic [NPIN-1:0] prev_q;
    logic [NPIN-1:0] sts_q;
    logic [NPIN-1:0] ev_w;

    always_comb begin
        ev_w = ((lvl_i & ~prev_q) & en_i.rise)
             | ((~lvl_i & prev_q) & en_i.fall)
             | (lvl_i & en_i.high)
             | (~lvl_i & en_i.low);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= '0;
            sts_q  <= '0;
        end else begin
            prev_q <= lvl_i;
            sts_q  <= (sts_q & ~clr_i) | ev_w;
        end
    end

    assign sts_o = sts_q;

    // R8: a status bit only falls when it was written with 1
    assert_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (($past(sts_q) & ~$past(clr_i) & ~sts_q) == '0));

    // R6 / R7: every detected event is recorded, even against a clear
    assert_event_kept_R7: assert property (@(posedge clk) disable iff (rst)
        (ev_w != '0) |=> ((sts_q & $past(ev_w)) == $past(ev_w)));
endmodule

// File: rtl/gpio_evt_bank.sv
module gpio_evt_bank
    import gpio_evt_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   bus_wr,
    input  logic                   bus_rd,
    input  logic [ADDR_W-1:0]      bus_addr,
    input  logic [DATA_W-1:0]      bus_wdata,
    output logic [DATA_W-1:0]      bus_rdata,
    input  logic [NPIN-1:0]        pin_in,
    output logic [NPIN-1:0]        pin_dout,
    output logic [NPIN-1:0]        pin_oe,
    output logic [NPIN*FSEL_W-1:0] pin_func,
    output logic                   irq
);
    logic [NPIN-1:0][FSEL_W-1:0] func_w;
    logic [NPIN-1:0]             lvl_w;
    logic [NPIN-1:0]             sts_w;
    logic [NPIN-1:0]             out_q;
    logic [NPIN-1:0]             clr_mask;
    logic [DATA_W-1:0]           sel_word;
    logic [DATA_W-1:0]           rd_mux;
    det_en_t                     en_q;
    logic                        wr_set, wr_clr, wr_sts;

    assign wr_set   = bus_wr && (bus_addr == RI_SET);
    assign wr_clr   = bus_wr && (bus_addr == RI_CLR);
    assign wr_sts   = bus_wr && (bus_addr == RI_STS);
    assign clr_mask = wr_sts ? bus_wdata[NPIN-1:0] : '0;

    // Per-pin function code storage
    for (genvar p = 0; p < NPIN; p++) begin : g_pin
        localparam int SI = p / PINS_PER_SEL;
        localparam int SO = (p % PINS_PER_SEL) * FSEL_W;
        logic [FSEL_W-1:0] code_q;

        always_ff @(posedge clk) begin
            if (rst)
                code_q <= FN_IN;
            else if (bus_wr && (bus_addr == ADDR_W'(SI)))
                code_q <= bus_wdata[SO +: FSEL_W];
        end

        assign func_w[p]                   = code_q;
        assign pin_oe[p]                   = (code_q == FN_OUT);
        assign pin_func[p*FSEL_W +: FSEL_W] = code_q;
    end

    always_comb begin
        sel_word = '0;
        for (int p = 0; p < NPIN; p++) begin
            if (sel_idx(p) == int'(bus_addr))
                sel_word[sel_off(p) +: FSEL_W] = func_w[p];
        end
    end

    // Output latches and detect enables
    always_ff @(posedge clk) begin
        if (rst) begin
            out_q <= '0;
            en_q  <= '0;
        end else begin
            if (wr_set)      out_q <= out_q | bus_wdata[NPIN-1:0];
            else if (wr_clr) out_q <= out_q & ~bus_wdata[NPIN-1:0];
            if (bus_wr) begin
                case (bus_addr)
                    RI_RISE: en_q.rise <= bus_wdata[NPIN-1:0];
                    RI_FALL: en_q.fall <= bus_wdata[NPIN-1:0];
                    RI_HIGH: en_q.high <= bus_wdata[NPIN-1:0];
                    RI_LOW:  en_q.low  <= bus_wdata[NPIN-1:0];
                    default: ;
                endcase
            end
        end
    end

    gpio_sync #(.W(NPIN), .STAGES(SYNC_DEPTH)) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i (pin_in),
        .q_o (lvl_w)
    );

    gpio_event u_event (
        .clk   (clk),
        .rst   (rst),
        .lvl_i (lvl_w),
        .en_i  (en_q),
        .clr_i (clr_mask),
        .sts_o (sts_w)
    );

    // Read path
    always_comb begin
        rd_mux = '0;
        if (int'(bus_addr) < NSEL) begin
            rd_mux = sel_word;
        end else begin
            case (bus_addr)
                RI_LVL:  rd_mux = DATA_W'(lvl_w);
                RI_RISE: rd_mux = DATA_W'(en_q.rise);
                RI_FALL: rd_mux = DATA_W'(en_q.fall);
                RI_HIGH: rd_mux = DATA_W'(en_q.high);
                RI_LOW:  rd_mux = DATA_W'(en_q.low);
                RI_STS:  rd_mux = DATA_W'(sts_w);
                default: rd_mux = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst)         bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rd_mux;
    end

    assign pin_dout = out_q;
    assign irq      = |sts_w;

    // R3: written ones appear on the outputs next cycle
    assert_set_R3: assert property (@(posedge clk) disable iff (rst)
        wr_set |=> ((pin_dout & $past(bus_wdata[NPIN-1:0])) == $past(bus_wdata[NPIN-1:0])));

    // R4: written ones are driven low next cycle
    assert_clear_R4: assert property (@(posedge clk) disable iff (rst)
        wr_clr |=> ((pin_dout & $past(bus_wdata[NPIN-1:0])) == '0));

    // R10: quiet outputs right after reset
    assert_reset_R10: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (pin_oe == '0 && pin_dout == '0 && !irq));

    // R11: read data holds when no read is issued
    assert_rdata_hold_R11: assert property (@(posedge clk) disable iff (rst)
        (!bus_rd && !$past(rst)) |=> $stable(bus_rdata));
endmodule

// File: tb/gpio_evt_bank_bench.sv
module gpio_evt_bank_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] pin_in = '0;
    logic [31:0] pin_dout;
    logic [31:0] pin_oe;
    logic [95:0] pin_func;
    logic        irq;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    typedef struct {
        logic [31:0] exp;
        string       tag;
    } sb_item_t;

    sb_item_t sb_q[$];

    always #4 clk = ~clk;

    gpio_evt_bank u_gpio_evt_bank (
        .clk       (clk),
        .rst       (rst),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pin_in    (pin_in),
        .pin_dout  (pin_dout),
        .pin_oe    (pin_oe),
        .pin_func  (pin_func),
        .irq       (irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    // Driver: issues a read and pushes the expected word to the scoreboard
    task automatic expect_read(input logic [3:0] a, input logic [31:0] exp, input string tag);
        sb_item_t it;
        it.exp = exp;
        it.tag = tag;
        @(negedge clk);
        sb_q.push_back(it);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Monitor: compares read data one cycle after each read strobe
    initial begin
        forever begin
            logic was_rd;
            sb_item_t it;
            @(posedge clk);
            was_rd = bus_rd;
            #1;
            if (was_rd) begin
                if (sb_q.size() == 0) begin
                    n_checks++; n_fail++;
                    $display("FAIL R11 actual=unexpected read expected=queued item");
                end else begin
                    it = sb_q.pop_front();
                    check(it.tag, bus_rdata, it.exp);
                end
            end
        end
    end

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10 reset state
        check("R10 pin_oe", pin_oe, 32'h0);
        check("R10 pin_dout", pin_dout, 32'h0);
        check("R10 irq", {31'h0, irq}, 32'h0);
        expect_read(4'd11, 32'h0, "R10 status");
        expect_read(4'd0, 32'h0, "R10 select word");

        // R1 / R2 function codes
        bus_write(4'd0, 32'hE800_0E01);
        bus_write(4'd3, 32'hFFFF_FFFF);
        expect_read(4'd0, 32'h2800_0E01, "R1 select word 0");
        expect_read(4'd3, 32'h0000_003F, "R1 select word 3");
        expect_read(4'd1, 32'h0, "R1 select word 1");
        idle(1);
        check("R2 pin_oe", pin_oe, 32'h0000_0001);
        check("R2 pin9 code", {29'h0, pin_func[29:27]}, 32'd5);
        check("R2 pin31 code", {29'h0, pin_func[95:93]}, 32'd7);

        // R3 / R4 output latches
        bus_write(4'd4, 32'h0000_00F0);
        check("R3 set", pin_dout, 32'h0000_00F0);
        bus_write(4'd4, 32'h0000_000F);
        check("R3 set keeps others", pin_dout, 32'h0000_00FF);
        bus_write(4'd5, 32'h0000_003C);
        check("R4 clear", pin_dout, 32'h0000_00C3);
        bus_write(4'd5, 32'h0);
        check("R4 zero clear", pin_dout, 32'h0000_00C3);

        // R5 level word
        pin_in = 32'hA5A5_0001;
        idle(4);
        expect_read(4'd6, 32'hA5A5_0001, "R5 level");
        pin_in = 32'h0;
        idle(4);
        expect_read(4'd6, 32'h0, "R5 level zero");
        expect_read(4'd11, 32'h0, "R6 no events while disabled");

        // R6 edge detection
        bus_write(4'd7, 32'h0000_0011);
        bus_write(4'd8, 32'h0000_0012);
        pin_in = 32'h0000_0013;
        idle(4);
        expect_read(4'd11, 32'h0000_0011, "R6 rising");
        check("R9 irq set", {31'h0, irq}, 32'h1);
        bus_write(4'd11, 32'h0000_0001);
        expect_read(4'd11, 32'h0000_0010, "R8 partial clear");
        bus_write(4'd11, 32'h0000_0010);
        expect_read(4'd11, 32'h0, "R8 full clear");
        check("R9 irq clear", {31'h0, irq}, 32'h0);
        pin_in = 32'h0;
        idle(4);
        expect_read(4'd11, 32'h0000_0012, "R6 falling and both");
        bus_write(4'd11, 32'hFFFF_FFFF);
        bus_write(4'd7, 32'h0);
        bus_write(4'd8, 32'h0);

        // R7 level detection
        bus_write(4'd9, 32'h0000_0100);
        bus_write(4'd10, 32'h0000_0200);
        expect_read(4'd11, 32'h0000_0200, "R7 low level");
        bus_write(4'd11, 32'h0000_0200);
        expect_read(4'd11, 32'h0000_0200, "R7 low level persists");
        pin_in = 32'h0000_0300;
        idle(4);
        bus_write(4'd11, 32'hFFFF_FFFF);
        expect_read(4'd11, 32'h0000_0100, "R8 high level survives clear");
        bus_write(4'd9, 32'h0);
        bus_write(4'd10, 32'h0);
        bus_write(4'd11, 32'hFFFF_FFFF);
        expect_read(4'd11, 32'h0, "R8 cleared after disable");
        check("R9 irq low", {31'h0, irq}, 32'h0);

        // R11 unmapped and write-only words
        expect_read(4'd15, 32'h0, "R11 unmapped");
        expect_read(4'd4, 32'h0, "R11 set word reads zero");
        idle(3);
        if (sb_q.size() != 0) begin
            n_checks++; n_fail++;
            $display("FAIL R11 actual=%0d pending expected=0", sb_q.size());
        end
        finish_run();
    end
endmodule